// File: doc/BRIEF.md
# Per-Pin Configurable GPIO Port Controller

This block controls one general-purpose I/O port of a microcontroller. Each pin has its own operating style. A pin can be a quasi-bidirectional line with a weak pull-up, a full push-pull output, a high-impedance input, or an open-drain output. Software writes an output latch and two mode registers, and each of these holds one bit per pin. From the latch and the two mode bits of each pin, the block derives three pad controls for that pin: a strong drive high, a strong drive low and a weak pull-up enable.

On the input side the block owns the pad input-buffer enable and a two-flop synchronizer. In power-down it shuts the input buffers of all pins except two groups: pins that are wake-capable by design, and pins that software has enabled as interrupt inputs. Some pins are taken over by the clock source or by the external reset option. These pins lose all GPIO drive. The reset defaults come from a tristate fuse input and an analog-pin mask.

Top module: `gpio_port_ctrl`

## Requirements
- R1: Mode bits {mode0[y], mode1[y]} = 2'b00 select quasi-bidirectional. With latch[y]=0 the pin drives strong-low only. With latch[y]=1 held, the pin has the weak pull-up only. Strong-high and strong-low are never both active on the same pin.
- R2: In quasi-bidirectional mode, a latch write that takes a bit from 0 to 1 drives strong-high on that pin for exactly the one cycle after the write edge.
- R3: Mode 2'b01 (push-pull) drives strong-high when latch[y]=1 and strong-low when latch[y]=0, with no pull-up.
- R4: Mode 2'b10 (input-only) leaves strong-high, strong-low and pull-up all off.
- R5: Mode 2'b11 (open-drain) drives strong-low when latch[y]=0 and nothing otherwise. It never drives strong-high, not even after a 0-to-1 latch write.
- R6: With fuse_tri_i=1 during reset, every pin resets to input-only (mode0 all ones, mode1 all zeros), and the latch resets to all ones.
- R7: With fuse_tri_i=0 during reset, pins flagged in analog_mask_i reset to input-only. All other pins reset to quasi-bidirectional with the latch at 1, so they show only the pull-up.
- R8: While pd_i=1, in_en_o is 1 only on WAKE_MASK pins and on pins with irq_en_i set. Once the gating has passed through the synchronizer, pin_rd_o reads 0 on every other pin. While pd_i=0, in_en_o is all ones.
- R9: pin_rd_o returns the gated pad value two clock edges after the pad changes, whatever the mode. latch_o returns the latch register.
- R10: clk_cfg_i=2'b01 (external clock) claims pin XIN_PIN. clk_cfg_i=2'b10 (crystal) claims pins XIN_PIN and XOUT_PIN. Codes 2'b00 and 2'b11 claim none. ext_rst_i=1 also claims RST_PIN. A claimed pin has all three pad controls off.
- R11: A write with wr_sel_i=0 updates the latch, 1 updates mode0, 2 updates mode1, and 3 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fuse_tri_i | input | 1 | Tristate fuse, used as the reset default |
| analog_mask_i | input | WIDTH | Pins that always reset to input-only |
| clk_cfg_i | input | 2 | Clock source: 0 internal, 1 external clock, 2 crystal, 3 none |
| ext_rst_i | input | 1 | External reset pin in use |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 0 latch, 1 mode0, 2 mode1 |
| wr_data_i | input | WIDTH | Write data |
| latch_o | output | WIDTH | Latch read-back |
| mode0_o | output | WIDTH | Mode0 read-back |
| mode1_o | output | WIDTH | Mode1 read-back |
| pad_i | input | WIDTH | Raw pad input |
| pd_i | input | 1 | Power-down active |
| irq_en_i | input | WIDTH | Pins enabled as interrupt inputs |
| in_en_o | output | WIDTH | Pad input-buffer enable |
| pin_rd_o | output | WIDTH | Synchronized pin read value |
| strong_hi_o | output | WIDTH | Strong drive high |
| strong_lo_o | output | WIDTH | Strong drive low |
| pullup_o | output | WIDTH | Weak pull-up enable |

## Verification
A corrupt latch or mode bit shows on the pad controls in the same cycle, because those controls are combinational from the registers. It also shows in the read-back. A kick flop that is stuck or stretched would show as a strong-high pulse that is missing or lasts two cycles, and the bench catches that in the cycle right after the write. Faults in the input path show two edges after a change at pad_i or pd_i, while a wrong buffer enable shows at once.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [1:0] {
    MODE_QUASI = 2'b00,
    MODE_PUSH  = 2'b01,
    MODE_INPUT = 2'b10,
    MODE_OPEN  = 2'b11
  } pin_mode_e;

  typedef enum logic [1:0] {
    SEL_LATCH = 2'b00,
    SEL_MODE0 = 2'b01,
    SEL_MODE1 = 2'b10,
    SEL_NONE  = 2'b11
  } reg_sel_e;

  typedef enum logic [1:0] {
    CLK_INT_RC = 2'b00,
    CLK_EXT    = 2'b01,
    CLK_XTAL   = 2'b10,
    CLK_RSVD   = 2'b11
  } clk_src_e;
endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fuse_tri_i,
  input  logic [WIDTH-1:0] analog_mask_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [WIDTH-1:0] wr_data_i,
  output logic [WIDTH-1:0] latch_o,
  output logic [WIDTH-1:0] latch_nxt_o,
  output logic [WIDTH-1:0] m0_o,
  output logic [WIDTH-1:0] m1_o
);
  logic [WIDTH-1:0] latch_q, m0_q, m1_q;
  logic [WIDTH-1:0] latch_d, m0_d, m1_d;

  always_comb begin
    latch_d = latch_q;
    m0_d    = m0_q;
    m1_d    = m1_q;
    if (wr_en_i) begin
      unique case (reg_sel_e'(wr_sel_i))
        SEL_LATCH: latch_d = wr_data_i;
        SEL_MODE0: m0_d    = wr_data_i;
        SEL_MODE1: m1_d    = wr_data_i;
        default:   ;
      endcase
    end
  end

  // fuse and analog mask are static straps; they set the async load value
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= '1;
      m0_q    <= fuse_tri_i ? '1 : analog_mask_i;
      m1_q    <= '0;
    end else begin
      latch_q <= latch_d;
      m0_q    <= m0_d;
      m1_q    <= m1_d;
    end
  end

  assign latch_o     = latch_q;
  assign latch_nxt_o = latch_d;
  assign m0_o        = m0_q;
  assign m1_o        = m1_q;

  p_sel_none_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == 2'b11) |=> ($stable(latch_q) && $stable(m0_q) && $stable(m1_q)));
endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] latch_i,
  input  logic [WIDTH-1:0] latch_nxt_i,
  input  logic [WIDTH-1:0] m0_i,
  input  logic [WIDTH-1:0] m1_i,
  input  logic [WIDTH-1:0] claim_i,
  output logic [WIDTH-1:0] strong_hi_o,
  output logic [WIDTH-1:0] strong_lo_o,
  output logic [WIDTH-1:0] pullup_o
);
  logic [WIDTH-1:0] kick_q;
  logic [WIDTH-1:0] quasi;

  // one-cycle strong-high after a 0->1 latch update
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) kick_q <= '0;
    else         kick_q <= latch_nxt_i & ~latch_i;
  end

  assign quasi = ~m0_i & ~m1_i;

  for (genvar g = 0; g < WIDTH; g++) begin : g_pin
    pin_mode_e mode;
    logic hi, lo, pu;
    assign mode = pin_mode_e'({m0_i[g], m1_i[g]});
    always_comb begin
      hi = 1'b0;
      lo = 1'b0;
      pu = 1'b0;
      if (!claim_i[g]) begin
        unique case (mode)
          MODE_QUASI: begin hi = kick_q[g]; lo = ~latch_i[g]; pu = latch_i[g]; end
          MODE_PUSH:  begin hi = latch_i[g]; lo = ~latch_i[g]; end
          MODE_OPEN:  lo = ~latch_i[g];
          default:    ;
        endcase
      end
    end
    assign strong_hi_o[g] = hi;
    assign strong_lo_o[g] = lo;
    assign pullup_o[g]    = pu;
  end

  p_no_fight_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strong_hi_o & strong_lo_o) == '0);
  p_kick_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strong_hi_o & quasi & $past(strong_hi_o & quasi)) == '0);
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned      WIDTH     = 8,
  parameter logic [WIDTH-1:0] WAKE_MASK = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] pad_i,
  input  logic             pd_i,
  input  logic [WIDTH-1:0] irq_en_i,
  output logic [WIDTH-1:0] in_en_o,
  output logic [WIDTH-1:0] pin_rd_o
);
  logic [WIDTH-1:0] keep;
  logic [WIDTH-1:0] gated;
  logic [WIDTH-1:0] ff1_q, ff2_q;

  assign keep    = WAKE_MASK | irq_en_i;
  assign in_en_o = pd_i ? keep : '1;
  assign gated   = pad_i & in_en_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ff1_q <= '0;
      ff2_q <= '0;
    end else begin
      ff1_q <= gated;
      ff2_q <= ff1_q;
    end
  end

  assign pin_rd_o = ff2_q;

  p_pd_read_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(pd_i, 2) && $past(pd_i)) |->
      ((pin_rd_o & ~($past(keep) | $past(keep, 2))) == '0));
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int unsigned      WIDTH     = 8,
  parameter logic [WIDTH-1:0] WAKE_MASK = 8'h0C,
  parameter int unsigned      XIN_PIN   = 0,
  parameter int unsigned      XOUT_PIN  = 1,
  parameter int unsigned      RST_PIN   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fuse_tri_i,
  input  logic [WIDTH-1:0] analog_mask_i,
  input  logic [1:0]       clk_cfg_i,
  input  logic             ext_rst_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [WIDTH-1:0] wr_data_i,
  output logic [WIDTH-1:0] latch_o,
  output logic [WIDTH-1:0] mode0_o,
  output logic [WIDTH-1:0] mode1_o,
  input  logic [WIDTH-1:0] pad_i,
  input  logic             pd_i,
  input  logic [WIDTH-1:0] irq_en_i,
  output logic [WIDTH-1:0] in_en_o,
  output logic [WIDTH-1:0] pin_rd_o,
  output logic [WIDTH-1:0] strong_hi_o,
  output logic [WIDTH-1:0] strong_lo_o,
  output logic [WIDTH-1:0] pullup_o
);
  localparam int unsigned MAX_PIN = WIDTH - 1;

  logic [WIDTH-1:0] latch_nxt;
  logic [WIDTH-1:0] claim;

  always_comb begin
    claim = '0;
    unique case (clk_src_e'(clk_cfg_i))
      CLK_EXT:  claim[XIN_PIN] = 1'b1;
      CLK_XTAL: begin claim[XIN_PIN] = 1'b1; claim[XOUT_PIN] = 1'b1; end
      default:  ;
    endcase
    if (ext_rst_i) claim[RST_PIN] = 1'b1;
  end

  gpio_port_regs #(.WIDTH(WIDTH)) u_regs (
    .clk_i, .rst_ni, .fuse_tri_i, .analog_mask_i,
    .wr_en_i, .wr_sel_i, .wr_data_i,
    .latch_o, .latch_nxt_o(latch_nxt), .m0_o(mode0_o), .m1_o(mode1_o)
  );

  gpio_pad_drive #(.WIDTH(WIDTH)) u_drive (
    .clk_i, .rst_ni, .latch_i(latch_o), .latch_nxt_i(latch_nxt),
    .m0_i(mode0_o), .m1_i(mode1_o), .claim_i(claim),
    .strong_hi_o, .strong_lo_o, .pullup_o
  );

  gpio_in_sync #(.WIDTH(WIDTH), .WAKE_MASK(WAKE_MASK)) u_sync (
    .clk_i, .rst_ni, .pad_i, .pd_i, .irq_en_i, .in_en_o, .pin_rd_o
  );

  initial begin
    p_pin_idx_r10: assert (XIN_PIN <= MAX_PIN && XOUT_PIN <= MAX_PIN && RST_PIN <= MAX_PIN);
  end

  p_input_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((strong_hi_o | strong_lo_o | pullup_o) & mode0_o & ~mode1_o) == '0);
  p_claim_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((strong_hi_o | strong_lo_o | pullup_o) & claim) == '0);
endmodule

// File: tb/gpio_port_ctrl_tb_top.sv
module gpio_port_ctrl_tb_top;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic fuse_tri = 1'b0;
  logic [W-1:0] analog_mask = '0;
  logic [1:0] clk_cfg = 2'b00;
  logic ext_rst = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = 2'b00;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] pad = '0;
  logic pd = 1'b0;
  logic [W-1:0] irq_en = '0;
  logic [W-1:0] latch, m0, m1, in_en, pin_rd, s_hi, s_lo, pu;

  always #5 clk = ~clk;

  gpio_port_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .fuse_tri_i(fuse_tri), .analog_mask_i(analog_mask),
    .clk_cfg_i(clk_cfg), .ext_rst_i(ext_rst), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .latch_o(latch), .mode0_o(m0), .mode1_o(m1), .pad_i(pad),
    .pd_i(pd), .irq_en_i(irq_en), .in_en_o(in_en), .pin_rd_o(pin_rd),
    .strong_hi_o(s_hi), .strong_lo_o(s_lo), .pullup_o(pu)
  );

  typedef struct {
    int          kind;
    logic [W-1:0] exp;
    string       req;
  } item_t;

  item_t sb_q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  function automatic logic [W-1:0] observe(int kind);
    case (kind)
      0: return s_hi;
      1: return s_lo;
      2: return pu;
      3: return in_en;
      4: return pin_rd;
      5: return latch;
      6: return m0;
      default: return m1;
    endcase
  endfunction

  function automatic string kname(int kind);
    case (kind)
      0: return "strong_hi";
      1: return "strong_lo";
      2: return "pullup";
      3: return "in_en";
      4: return "pin_rd";
      5: return "latch";
      6: return "mode0";
      default: return "mode1";
    endcase
  endfunction

  // monitor: compares queued expectations away from the active edge
  initial begin
    forever begin
      item_t it;
      logic [W-1:0] act;
      @(negedge clk);
      while (sb_q.size() > 0) begin
        it = sb_q.pop_front();
        act = observe(it.kind);
        n_cmp++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s %s actual=%h expected=%h", it.req, kname(it.kind), act, it.exp);
        end
      end
    end
  end

  task automatic expect_v(int kind, logic [W-1:0] exp, string req);
    item_t it;
    it.kind = kind; it.exp = exp; it.req = req;
    sb_q.push_back(it);
  endtask

  task automatic expect_drive(logic [W-1:0] hi, logic [W-1:0] lo, logic [W-1:0] p, string req);
    expect_v(0, hi, req); expect_v(1, lo, req); expect_v(2, p, req);
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(logic [1:0] sel, logic [W-1:0] data);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic do_reset(logic fuse, logic [W-1:0] amask);
    fuse_tri = fuse; analog_mask = amask;
    rst_ni = 1'b0;
    tick(); tick();
    rst_ni = 1'b1;
  endtask

  initial begin
    // R6: fuse set -> all input-only
    do_reset(1'b1, 8'hF0);
    expect_v(5, 8'hFF, "R6"); expect_v(6, 8'hFF, "R6"); expect_v(7, 8'h00, "R6");
    expect_drive(8'h00, 8'h00, 8'h00, "R6");
    tick();
    // R7: fuse clear -> analog pins input-only, rest quasi with pull-up
    do_reset(1'b0, 8'hF0);
    expect_v(5, 8'hFF, "R7"); expect_v(6, 8'hF0, "R7"); expect_v(7, 8'h00, "R7");
    expect_drive(8'h00, 8'h00, 8'h0F, "R7");
    tick();
    // R1: quasi low pins drive strong-low, high pins pull-up only
    wr(2'd0, 8'hFA);
    expect_drive(8'h00, 8'h05, 8'h0A, "R1");
    tick();
    // R2: 0->1 gives a single strong-high cycle
    wr(2'd0, 8'hFF);
    expect_drive(8'h05, 8'h00, 8'h0F, "R2");
    tick();
    expect_drive(8'h00, 8'h00, 8'h0F, "R2");
    // R3: push-pull on pins 3..0
    wr(2'd2, 8'h0F);
    expect_drive(8'h0F, 8'h00, 8'h00, "R3");
    wr(2'd0, 8'hA5);
    expect_drive(8'h05, 8'h0A, 8'h00, "R3");
    expect_v(5, 8'hA5, "R9");
    // R4: all input-only
    wr(2'd2, 8'h00);
    wr(2'd1, 8'hFF);
    expect_drive(8'h00, 8'h00, 8'h00, "R4");
    expect_v(6, 8'hFF, "R11"); expect_v(7, 8'h00, "R11");
    // R9: synchronized read, two edges
    pad = 8'h5A;
    tick();
    expect_v(4, 8'h00, "R9");
    tick();
    expect_v(4, 8'h5A, "R9"); expect_v(5, 8'hA5, "R9"); expect_v(3, 8'hFF, "R8");
    // R5: open-drain
    wr(2'd2, 8'hFF);
    expect_drive(8'h00, 8'h5A, 8'h00, "R5");
    wr(2'd0, 8'h00);
    expect_drive(8'h00, 8'hFF, 8'h00, "R5");
    wr(2'd0, 8'hFF);
    expect_drive(8'h00, 8'h00, 8'h00, "R5");
    // R11: select 3 writes nothing
    wr(2'd3, 8'h00);
    tick();
    expect_v(5, 8'hFF, "R11"); expect_v(6, 8'hFF, "R11"); expect_v(7, 8'hFF, "R11");
    // R10: claimed pins lose drive
    wr(2'd0, 8'h00);
    expect_v(1, 8'hFF, "R10");
    tick();
    clk_cfg = 2'b10; ext_rst = 1'b1;
    expect_v(1, 8'hF8, "R10");
    tick();
    clk_cfg = 2'b01; ext_rst = 1'b0;
    expect_v(1, 8'hFE, "R10");
    tick();
    clk_cfg = 2'b11;
    expect_v(1, 8'hFF, "R10");
    tick();
    clk_cfg = 2'b00;
    // R8: power-down gating
    pad = 8'hFF; pd = 1'b1; irq_en = 8'h10;
    expect_v(3, 8'h1C, "R8");
    tick(); tick();
    expect_v(4, 8'h1C, "R8");
    tick();
    pd = 1'b0;
    expect_v(3, 8'hFF, "R8");
    tick(); tick();
    expect_v(4, 8'hFF, "R9");
    tick(); tick();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog all-R actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule